// File: doc/BRIEF.md
# Host Register Window with Indirect Access

This block is the host-facing register window of a network controller. It occupies four 32-bit words. A host driver uses the window to do four things. It issues commands: starting the transmit or receive channel, switching interrupts on or off, loading an interrupt pacing value, and resetting the controller. It gives a list address for channel starts. It reads a vector-style interrupt code. It reaches an internal register file or SRAM through an address/data pair.

The interrupt code lines up with the upper half of the command word. A driver acknowledges an interrupt by writing the code it just read back into the command word's upper 16 bits. The code always has its two lowest bits clear, so the driver can use it as a jump-table offset. A fatal adapter check takes over both the code and the channel-parameter word until the controller is reset. The host addresses the window by word index: 0 is command, 1 is channel parameter, 2 is interrupt code plus indirect address, and 3 is the indirect data port.

Top module: `host_reg_window`

## Requirements
- R1: After rstN is released, reads of words 0, 1 and 2 return zero, hostIrq is low, and txRun, rxRun and pacingSel are zero.
- R2: A read of word 0, 1 or 2 that is accepted on a clock edge gives hostRdValid high for one cycle after that edge, with the data. Word 2 reads as {interrupt code[15:0], indirect address[15:0]}.
- R3: The interrupt code for pending source k (irqEvent[k], k = 0..3) is (k+1)*4. The lowest pending index wins. An adapter check overrides every source with code 0x001C. With nothing pending the code is 0. Code bits 1:0 are always zero.
- R4: A write to word 0 with both byte lanes 3 and 2 enabled clears the pending source whose code equals write data bits 31:16. No other source is cleared. A value that matches no source, or a write without both lanes, clears nothing. The code shows the next pending source in the cycle after the write edge.
- R5: hostIrq is high exactly when interrupts are enabled and some source or an adapter check is pending. The enable is switched with lane 0 of word 0: bit 2 turns it on, bit 3 turns it off, and bit 3 wins if both are set. hostIrq falls in the cycle after the edge that acknowledges the last pending source.
- R6: A lane-0 command write with bit 0 (transmit) or bit 1 (receive) set pulses txGoStb or rxGoStb for one cycle after the edge and sets txRun or rxRun. goAddr carries the word 1 list address. These go bits are ignored while an adapter check is pending.
- R7: Every lane-0 command write loads the pacing value from bits 6:4 onto pacingSel. Word 0 reads back as tx run in bit 0, rx run in bit 1, interrupt enable in bit 2 and pacing in bits 6:4, with all other bits zero.
- R8: A lane-0 command write with bit 7 set returns every register, pending source, adapter check and run flag to zero. Every other bit of that write, including the go bits and the acknowledge field, is ignored.
- R9: An adapter check pulse latches the error detail of the first check only. From then on, word 1 reads that detail and the code reads 0x001C. Acknowledge does not clear it; only reset does.
- R10: Writes to word 1 update only the enabled byte lanes. Writes to word 2 update the indirect address from lanes 1 and 0 only; lanes 3 and 2 of word 2 are ignored.
- R11: A write to word 3 gives intWrStb high for exactly one cycle after the edge, with the write data and byte enables, at intAddr equal to the indirect address.
- R12: A read of word 3 raises intRdStb for one cycle after the edge and holds hostBusy high until intRdReady is seen. hostRdValid then carries intRdData in the cycle after the ready edge. While hostBusy is high, host accesses are ignored.
- R13: If an event on a source arrives in the same cycle as the acknowledge of that source, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write request |
| hostRdEn | input | 1 | Host read request |
| hostWord | input | 2 | Word index within the window |
| hostBe | input | 4 | Byte-lane enables of a write |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data |
| hostRdValid | output | 1 | Read data valid, one cycle |
| hostBusy | output | 1 | Indirect read in flight; accesses ignored |
| hostIrq | output | 1 | Interrupt line to the host |
| irqEvent | input | NUM_IRQ | Interrupt source event pulses |
| adapterChk | input | 1 | Fatal error pulse |
| adapterErr | input | 32 | Error detail captured with adapterChk |
| txGoStb | output | 1 | Transmit channel start pulse |
| rxGoStb | output | 1 | Receive channel start pulse |
| goAddr | output | 32 | List address for the channel start |
| txRun | output | 1 | Transmit channel started |
| rxRun | output | 1 | Receive channel started |
| pacingSel | output | PACE_W | Interrupt pacing selection |
| intAddr | output | DIO_AW | Indirect address |
| intRdStb | output | 1 | Internal read strobe |
| intWrStb | output | 1 | Internal write strobe |
| intWrData | output | 32 | Internal write data |
| intWrBe | output | 4 | Internal write byte enables |
| intRdData | input | 32 | Internal read data |
| intRdReady | input | 1 | Internal read data valid |

## Verification
The hardest situations to reach are the collisions on the pending flags. One is an event on a source arriving in the very cycle its acknowledge is written. Another is two sources pending at once, where acknowledging the higher-priority one has to expose the other. The stimulus gets there by driving an irqEvent pulse in the same cycle as the acknowledge write, and by raising two sources before acknowledging out of priority order. A behavioural model tracks the expected pending set and the interrupt line on every clock. The adapter check is also forced while sources are pending and a start command is issued, to show that it overrides the code and blocks the go bits.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W = WORD_W / 8;

  // command word lower-half bit positions
  localparam int CMD_TX_GO = 0;
  localparam int CMD_RX_GO = 1;
  localparam int CMD_INT_ON = 2;
  localparam int CMD_INT_OFF = 3;
  localparam int CMD_PACE_LSB = 4;
  localparam int CMD_RST = 7;
  localparam int ACK_LSB = 16;

  typedef enum logic [1:0] {
    OFS_CMD  = 2'd0,
    OFS_PARM = 2'd1,
    OFS_IRQ  = 2'd2,
    OFS_DATA = 2'd3
  } wordSel_e;

  typedef struct packed {
    logic cmdLoWr;
    logic ackWr;
    logic softRst;
    logic [BE_W-1:0] parmBe;
    logic [1:0] dioBe;
    logic rdLoad;
    wordSel_e rdSel;
    logic indLoad;
  } hostStb_t;
endpackage

// File: rtl/hrw_ctrl.sv
module hrw_ctrl
  import hrw_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hostWrEn,
  input  logic hostRdEn,
  input  logic [1:0] hostWord,
  input  logic [BE_W-1:0] hostBe,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic intRdReady,
  output hostStb_t stb,
  output logic hostBusy,
  output logic hostRdValid,
  output logic intRdStb,
  output logic intWrStb,
  output logic [WORD_W-1:0] intWrData,
  output logic [BE_W-1:0] intWrBe
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlSt_e;
  ctrlSt_e st;
  wordSel_e word;
  logic wrAcc, rdAcc, rstHit, isCmd;

  assign word = wordSel_e'(hostWord);
  assign hostBusy = (st == ST_WAIT);

  always_comb begin
    wrAcc = hostWrEn && (st == ST_IDLE);
    rdAcc = hostRdEn && !hostWrEn && (st == ST_IDLE);
    isCmd = wrAcc && (word == OFS_CMD);
    rstHit = isCmd && hostBe[0] && hostWrData[CMD_RST];
    stb = '0;
    stb.softRst = rstHit;
    stb.cmdLoWr = isCmd && hostBe[0] && !rstHit;
    stb.ackWr = isCmd && (&hostBe[3:2]) && !rstHit;
    stb.parmBe = (wrAcc && word == OFS_PARM) ? hostBe : '0;
    stb.dioBe = (wrAcc && word == OFS_IRQ) ? hostBe[1:0] : 2'b00;
    stb.rdLoad = rdAcc && (word != OFS_DATA);
    stb.rdSel = word;
    stb.indLoad = (st == ST_WAIT) && intRdReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      intRdStb <= 1'b0;
      intWrStb <= 1'b0;
      intWrData <= '0;
      intWrBe <= '0;
      hostRdValid <= 1'b0;
    end else begin
      intRdStb <= rdAcc && (word == OFS_DATA);
      intWrStb <= wrAcc && (word == OFS_DATA);
      if (wrAcc && word == OFS_DATA) begin
        intWrData <= hostWrData;
        intWrBe <= hostBe;
      end
      hostRdValid <= stb.rdLoad || stb.indLoad;
      if (rdAcc && word == OFS_DATA) st <= ST_WAIT;
      else if (stb.indLoad) st <= ST_IDLE;
    end
  end

  // R12
  rd_strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    intRdStb |=> !intRdStb);

  // R12
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid |-> !hostBusy);

  // R12
  rd_strobe_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    intRdStb |-> hostBusy);
endmodule

// File: rtl/hrw_dpath.sv
module hrw_dpath
  import hrw_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int DIO_AW = 16,
  parameter int PACE_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  hostStb_t stb,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic [NUM_IRQ-1:0] irqEvent,
  input  logic adapterChk,
  input  logic [WORD_W-1:0] adapterErr,
  input  logic [WORD_W-1:0] intRdData,
  output logic [WORD_W-1:0] hostRdData,
  output logic hostIrq,
  output logic txGoStb,
  output logic rxGoStb,
  output logic [WORD_W-1:0] goAddr,
  output logic txRun,
  output logic rxRun,
  output logic [PACE_W-1:0] pacingSel,
  output logic [DIO_AW-1:0] intAddr
);
  localparam int TYPE_W = $clog2(NUM_IRQ + 2);
  localparam int CODE_W = 16;
  localparam logic [CODE_W-1:0] ADAPT_CODE = CODE_W'(((1 << TYPE_W) - 1) << 2);

  function automatic logic [CODE_W-1:0] codeOf(input int t);
    return CODE_W'(t << 2);
  endfunction

  logic [WORD_W-1:0] parm, adErr;
  logic [DIO_AW-1:0] dioAddr;
  logic [15:0] dioNext;
  logic [NUM_IRQ-1:0] pend;
  logic adChk, intEn;
  logic [CODE_W-1:0] irqCode;
  logic goAllowed;

  assign goAddr = parm;
  assign intAddr = dioAddr;
  assign goAllowed = stb.cmdLoWr && !adChk;

  // channel parameter, byte-lane writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parm <= '0;
    else if (stb.softRst) parm <= '0;
    else begin
      for (int b = 0; b < BE_W; b++)
        if (stb.parmBe[b]) parm[b*8 +: 8] <= hostWrData[b*8 +: 8];
    end
  end

  // indirect address, lanes 1:0 only
  always_comb begin
    dioNext = 16'(dioAddr);
    if (stb.dioBe[0]) dioNext[7:0] = hostWrData[7:0];
    if (stb.dioBe[1]) dioNext[15:8] = hostWrData[15:8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dioAddr <= '0;
    else if (stb.softRst) dioAddr <= '0;
    else dioAddr <= dioNext[DIO_AW-1:0];
  end

  // command state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= 1'b0;
      pacingSel <= '0;
      txRun <= 1'b0;
      rxRun <= 1'b0;
      txGoStb <= 1'b0;
      rxGoStb <= 1'b0;
    end else if (stb.softRst) begin
      intEn <= 1'b0;
      pacingSel <= '0;
      txRun <= 1'b0;
      rxRun <= 1'b0;
      txGoStb <= 1'b0;
      rxGoStb <= 1'b0;
    end else begin
      txGoStb <= goAllowed && hostWrData[CMD_TX_GO];
      rxGoStb <= goAllowed && hostWrData[CMD_RX_GO];
      if (goAllowed && hostWrData[CMD_TX_GO]) txRun <= 1'b1;
      if (goAllowed && hostWrData[CMD_RX_GO]) rxRun <= 1'b1;
      if (stb.cmdLoWr) begin
        pacingSel <= hostWrData[CMD_PACE_LSB +: PACE_W];
        if (hostWrData[CMD_INT_OFF]) intEn <= 1'b0;
        else if (hostWrData[CMD_INT_ON]) intEn <= 1'b1;
      end
    end
  end

  // pending interrupt sources
  for (genvar i = 0; i < NUM_IRQ; i++) begin : gPend
    logic ackHit;
    assign ackHit = stb.ackWr && (hostWrData[ACK_LSB +: CODE_W] == codeOf(i + 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pend[i] <= 1'b0;
      else if (stb.softRst) pend[i] <= 1'b0;
      else if (irqEvent[i]) pend[i] <= 1'b1;
      else if (ackHit) pend[i] <= 1'b0;
    end
  end

  // adapter check, first detail kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adChk <= 1'b0;
      adErr <= '0;
    end else if (stb.softRst) begin
      adChk <= 1'b0;
      adErr <= '0;
    end else if (adapterChk && !adChk) begin
      adChk <= 1'b1;
      adErr <= adapterErr;
    end
  end

  // code: adapter check first, then lowest pending index
  always_comb begin
    irqCode = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (pend[i]) irqCode = codeOf(i + 1);
    if (adChk) irqCode = ADAPT_CODE;
  end

  assign hostIrq = intEn && ((|pend) || adChk);

  // read data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostRdData <= '0;
    else if (stb.rdLoad) begin
      unique case (stb.rdSel)
        OFS_CMD:  hostRdData <= WORD_W'({pacingSel, 1'b0, intEn, rxRun, txRun});
        OFS_PARM: hostRdData <= adChk ? adErr : parm;
        OFS_IRQ:  hostRdData <= {irqCode, 16'(dioAddr)};
        default:  hostRdData <= '0;
      endcase
    end else if (stb.indLoad) hostRdData <= intRdData;
  end

  // R6
  go_from_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txGoStb || rxGoStb) |-> $past(stb.cmdLoWr));

  // R8
  soft_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (!hostIrq && !txRun && !rxRun && !txGoStb && !rxGoStb));

  // R9
  adapter_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adChk && !stb.softRst) |=> adChk);

  // R5
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> ((|pend) || adChk));
endmodule

// File: rtl/host_reg_window.sv
module host_reg_window
  import hrw_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int DIO_AW = 16,
  parameter int PACE_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostWrEn,
  input  logic hostRdEn,
  input  logic [1:0] hostWord,
  input  logic [3:0] hostBe,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic hostRdValid,
  output logic hostBusy,
  output logic hostIrq,
  input  logic [NUM_IRQ-1:0] irqEvent,
  input  logic adapterChk,
  input  logic [31:0] adapterErr,
  output logic txGoStb,
  output logic rxGoStb,
  output logic [31:0] goAddr,
  output logic txRun,
  output logic rxRun,
  output logic [PACE_W-1:0] pacingSel,
  output logic [DIO_AW-1:0] intAddr,
  output logic intRdStb,
  output logic intWrStb,
  output logic [31:0] intWrData,
  output logic [3:0] intWrBe,
  input  logic [31:0] intRdData,
  input  logic intRdReady
);
  hostStb_t stb;

  hrw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostWord(hostWord), .hostBe(hostBe), .hostWrData(hostWrData),
    .intRdReady(intRdReady), .stb(stb), .hostBusy(hostBusy),
    .hostRdValid(hostRdValid), .intRdStb(intRdStb), .intWrStb(intWrStb),
    .intWrData(intWrData), .intWrBe(intWrBe)
  );

  hrw_dpath #(.NUM_IRQ(NUM_IRQ), .DIO_AW(DIO_AW), .PACE_W(PACE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrData(hostWrData),
    .irqEvent(irqEvent), .adapterChk(adapterChk), .adapterErr(adapterErr),
    .intRdData(intRdData), .hostRdData(hostRdData), .hostIrq(hostIrq),
    .txGoStb(txGoStb), .rxGoStb(rxGoStb), .goAddr(goAddr), .txRun(txRun),
    .rxRun(rxRun), .pacingSel(pacingSel), .intAddr(intAddr)
  );
endmodule

// File: tb/host_reg_window_tb.sv
module host_reg_window_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 0, hostRdEn = 0;
  logic [1:0] hostWord = 0;
  logic [3:0] hostBe = 0;
  logic [31:0] hostWrData = 0;
  logic [31:0] hostRdData;
  logic hostRdValid, hostBusy, hostIrq;
  logic [3:0] irqEvent = 0;
  logic adapterChk = 0;
  logic [31:0] adapterErr = 0;
  logic txGoStb, rxGoStb, txRun, rxRun;
  logic [31:0] goAddr;
  logic [2:0] pacingSel;
  logic [15:0] intAddr;
  logic intRdStb, intWrStb;
  logic [31:0] intWrData;
  logic [3:0] intWrBe;
  logic [31:0] intRdData = 0;
  logic intRdReady = 0;

  int vectors = 0, fails = 0, cyc = 0;
  bit started = 0, finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  host_reg_window u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // internal storage responder
  logic [31:0] mem [16];
  int rspCnt = 0;
  logic [3:0] rspIdx = 0;
  initial for (int i = 0; i < 16; i++) mem[i] = 0;

  always @(negedge clk) begin
    intRdReady = 1'b0;
    if (rspCnt == 1) begin
      intRdReady = 1'b1;
      intRdData = mem[rspIdx];
    end
    if (rspCnt > 0) rspCnt--;
    if (intRdStb) begin rspCnt = 3; rspIdx = intAddr[3:0]; end
    if (intWrStb)
      for (int b = 0; b < 4; b++)
        if (intWrBe[b]) mem[intAddr[3:0]][b*8 +: 8] = intWrData[b*8 +: 8];
  end

  // behavioural reference model
  bit mPend [4];
  bit mAd, mIntEn, mTx, mRx, mBusy, mTxGo, mRxGo, mRdValid, mIntRd, mIntWr;
  logic [31:0] mParm, mAdErr, mRdData, mIntWrData;
  logic [3:0] mIntWrBe;
  logic [2:0] mPace;
  logic [15:0] mDio;

  function automatic logic [15:0] mCode();
    if (mAd) return 16'h001C;
    for (int i = 0; i < 4; i++) if (mPend[i]) return 16'((i + 1) * 4);
    return 16'h0000;
  endfunction

  task automatic mClear();
    foreach (mPend[i]) mPend[i] = 0;
    mAd = 0; mIntEn = 0; mTx = 0; mRx = 0; mParm = 0; mAdErr = 0;
    mPace = 0; mDio = 0;
  endtask

  initial begin
    mClear(); mBusy = 0; mTxGo = 0; mRxGo = 0; mRdValid = 0; mIntRd = 0;
    mIntWr = 0; mRdData = 0; mIntWrData = 0; mIntWrBe = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mClear(); mBusy = 0; mTxGo = 0; mRxGo = 0; mRdValid = 0;
      mIntRd = 0; mIntWr = 0;
    end else begin
      bit wr, rd, rst;
      bit nPend [4];
      wr = hostWrEn && !mBusy;
      rd = hostRdEn && !hostWrEn && !mBusy;
      rst = 0;
      mTxGo = 0; mRxGo = 0; mRdValid = 0; mIntRd = 0; mIntWr = 0;
      if (rd && hostWord != 3) begin
        mRdValid = 1;
        case (hostWord)
          0: mRdData = {25'b0, mPace, 1'b0, mIntEn, mRx, mTx};
          1: mRdData = mAd ? mAdErr : mParm;
          default: mRdData = {mCode(), mDio};
        endcase
      end
      if (mBusy && intRdReady) begin mRdValid = 1; mRdData = intRdData; mBusy = 0; end
      if (rd && hostWord == 3) begin mBusy = 1; mIntRd = 1; end
      if (wr && hostWord == 3) begin mIntWr = 1; mIntWrData = hostWrData; mIntWrBe = hostBe; end
      nPend = mPend;
      if (wr && hostWord == 0) begin
        if (hostBe[0] && hostWrData[7]) begin
          rst = 1; mClear(); foreach (nPend[i]) nPend[i] = 0;
        end else begin
          if (hostBe[0]) begin
            mPace = hostWrData[6:4];
            if (hostWrData[3]) mIntEn = 0; else if (hostWrData[2]) mIntEn = 1;
            if (!mAd && hostWrData[0]) begin mTxGo = 1; mTx = 1; end
            if (!mAd && hostWrData[1]) begin mRxGo = 1; mRx = 1; end
          end
          if (hostBe[3] && hostBe[2])
            for (int i = 0; i < 4; i++)
              if (hostWrData[31:16] == 16'((i + 1) * 4)) nPend[i] = 0;
        end
      end
      if (wr && hostWord == 1)
        for (int b = 0; b < 4; b++) if (hostBe[b]) mParm[b*8 +: 8] = hostWrData[b*8 +: 8];
      if (wr && hostWord == 2) begin
        if (hostBe[0]) mDio[7:0] = hostWrData[7:0];
        if (hostBe[1]) mDio[15:8] = hostWrData[15:8];
      end
      if (!rst) begin
        for (int i = 0; i < 4; i++) if (irqEvent[i]) nPend[i] = 1;
        if (adapterChk && !mAd) begin mAd = 1; mAdErr = adapterErr; end
      end
      mPend = nPend;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      bit anyP;
      anyP = mAd;
      foreach (mPend[i]) anyP |= mPend[i];
      chk("R5 hostIrq", 32'(hostIrq), 32'(mIntEn && anyP));
      chk("R6 txRun", 32'(txRun), 32'(mTx));
      chk("R6 rxRun", 32'(rxRun), 32'(mRx));
      chk("R6 txGoStb", 32'(txGoStb), 32'(mTxGo));
      chk("R6 rxGoStb", 32'(rxGoStb), 32'(mRxGo));
      chk("R6 goAddr", goAddr, mParm);
      chk("R7 pacingSel", 32'(pacingSel), 32'(mPace));
      chk("R10 intAddr", 32'(intAddr), 32'(mDio));
      chk("R11 intWrStb", 32'(intWrStb), 32'(mIntWr));
      if (mIntWr) begin
        chk("R11 intWrData", intWrData, mIntWrData);
        chk("R11 intWrBe", 32'(intWrBe), 32'(mIntWrBe));
      end
      chk("R12 intRdStb", 32'(intRdStb), 32'(mIntRd));
      chk("R12 hostBusy", 32'(hostBusy), 32'(mBusy));
      chk("R2 hostRdValid", 32'(hostRdValid), 32'(mRdValid));
      if (mRdValid) chk("R2 hostRdData", hostRdData, mRdData);
    end
  end

  task automatic hostWrite(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1; hostWord = w; hostBe = be; hostWrData = d;
    @(negedge clk);
    hostWrEn = 0; hostBe = 0;
  endtask

  task automatic readExpect(input string tag, input logic [1:0] w, input logic [31:0] exp);
    @(negedge clk);
    hostRdEn = 1; hostWord = w;
    @(negedge clk);
    hostRdEn = 0;
    while (!hostRdValid) @(negedge clk);
    chk(tag, hostRdData, exp);
  endtask

  task automatic pulseEvent(input int k);
    @(negedge clk);
    irqEvent[k] = 1;
    @(negedge clk);
    irqEvent = 0;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected below 20000", cyc);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    started = 1;
    // R1 reset state
    chk("R1 hostIrq", 32'(hostIrq), 0);
    chk("R1 pacingSel", 32'(pacingSel), 0);
    readExpect("R1 word0", 2'd0, 32'h0);
    readExpect("R1 word1", 2'd1, 32'h0);
    readExpect("R1 word2", 2'd2, 32'h0);

    // R10 byte lanes
    hostWrite(2'd1, 4'b1111, 32'h1234_5678);
    hostWrite(2'd1, 4'b0010, 32'hFFFF_ABFF);
    readExpect("R10 parm lanes", 2'd1, 32'h1234_AB78);
    hostWrite(2'd2, 4'b1111, 32'hFFFF_0005);
    readExpect("R10 dio upper ignored", 2'd2, 32'h0000_0005);

    // R11 / R12 indirect access
    hostWrite(2'd3, 4'b1111, 32'hDEAD_BEEF);
    hostWrite(2'd2, 4'b0011, 32'h0000_0006);
    hostWrite(2'd3, 4'b0011, 32'h1122_3344);
    hostWrite(2'd2, 4'b0001, 32'h0000_0005);
    readExpect("R12 indirect read 5", 2'd3, 32'hDEAD_BEEF);
    hostWrite(2'd2, 4'b0001, 32'h0000_0006);
    readExpect("R12 indirect read 6", 2'd3, 32'h0000_3344);

    // R3 / R4 / R5 interrupt code and acknowledge
    hostWrite(2'd0, 4'b0001, 32'h4);
    chk("R5 no pending", 32'(hostIrq), 0);
    pulseEvent(2);
    chk("R5 irq raised", 32'(hostIrq), 1);
    readExpect("R3 code src2", 2'd2, 32'h000C_0006);
    pulseEvent(0);
    readExpect("R3 priority src0", 2'd2, 32'h0004_0006);
    hostWrite(2'd0, 4'b0100, 32'h000C_0000);
    readExpect("R4 single lane no ack", 2'd2, 32'h0004_0006);
    hostWrite(2'd0, 4'b1100, 32'h000C_0000);
    readExpect("R4 ack src2 only", 2'd2, 32'h0004_0006);
    hostWrite(2'd0, 4'b1100, 32'h0008_0000);
    chk("R4 unmatched ack", 32'(hostIrq), 1);
    hostWrite(2'd0, 4'b1100, 32'h0004_0000);
    chk("R5 irq falls after last ack", 32'(hostIrq), 0);
    readExpect("R4 nothing pending", 2'd2, 32'h0000_0006);

    // R13 event and ack in the same cycle
    pulseEvent(1);
    @(negedge clk);
    hostWrEn = 1; hostWord = 2'd0; hostBe = 4'b1100; hostWrData = 32'h0008_0000;
    irqEvent[1] = 1;
    @(negedge clk);
    hostWrEn = 0; hostBe = 0; irqEvent = 0;
    readExpect("R13 still pending", 2'd2, 32'h0008_0006);
    hostWrite(2'd0, 4'b1100, 32'h0008_0000);
    chk("R13 cleared later", 32'(hostIrq), 0);

    // R5 enable and disable
    pulseEvent(3);
    hostWrite(2'd0, 4'b0001, 32'h8);
    chk("R5 disabled", 32'(hostIrq), 0);
    hostWrite(2'd0, 4'b0001, 32'h4);
    chk("R5 enabled", 32'(hostIrq), 1);
    hostWrite(2'd0, 4'b0001, 32'hC);
    chk("R5 off wins", 32'(hostIrq), 0);
    hostWrite(2'd0, 4'b0001, 32'h4);
    hostWrite(2'd0, 4'b1100, 32'h0010_0000);
    chk("R5 src3 acked", 32'(hostIrq), 0);

    // R6 / R7 channel start and pacing
    hostWrite(2'd1, 4'b1111, 32'h0004_0000);
    hostWrite(2'd0, 4'b0001, 32'h53);
    chk("R6 txGoStb", 32'(txGoStb), 1);
    chk("R6 rxGoStb", 32'(rxGoStb), 1);
    chk("R6 goAddr", goAddr, 32'h0004_0000);
    chk("R7 pacingSel", 32'(pacingSel), 5);
    readExpect("R7 readback", 2'd0, 32'h57);

    // R9 adapter check
    @(negedge clk);
    adapterChk = 1; adapterErr = 32'hBAD0_0001;
    @(negedge clk);
    adapterErr = 32'h0000_2222;
    @(negedge clk);
    adapterChk = 0;
    readExpect("R9 detail", 2'd1, 32'hBAD0_0001);
    readExpect("R9 code", 2'd2, 32'h001C_0006);
    hostWrite(2'd0, 4'b1100, 32'h001C_0000);
    readExpect("R9 ack ignored", 2'd2, 32'h001C_0006);
    hostWrite(2'd0, 4'b0001, 32'h5);
    chk("R6 go blocked", 32'(txGoStb), 0);
    chk("R9 irq held", 32'(hostIrq), 1);

    // R8 soft reset over other bits
    pulseEvent(1);
    hostWrite(2'd0, 4'b1111, 32'h0008_0087);
    chk("R8 no go", 32'(txGoStb), 0);
    chk("R8 irq low", 32'(hostIrq), 0);
    chk("R8 tx stopped", 32'(txRun), 0);
    readExpect("R8 word0", 2'd0, 32'h0);
    readExpect("R8 word1", 2'd1, 32'h0);
    readExpect("R8 word2", 2'd2, 32'h0);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule